// File: doc/BRIEF.md
# 64-bit SEC-DED Check Generator and Syndrome Decoder

This block protects a 64-bit memory word with 8 check bits. On the write side it forms the check bits for a data word. Each check bit is the even parity of the data bits picked out by one fixed, irregular 64-bit selection mask. On the read side it takes a data word and the check bits stored with it, and recomputes the check bits. The XOR of recomputed and stored check bits is the syndrome.

The decoder compares the syndrome against the 64 per-data-bit columns of the mask set. Column b holds bit b of every mask. A match names the failing data bit, and that bit is flipped in the delivered word. If no column matches, a syndrome with one bit set names a failing check bit. Any other nonzero syndrome is reported as uncorrectable. A parameter selects whether the decode results leave through a register stage or straight from the logic.

Top module: `secded64_codec`

## Requirements
- R1: `enc_check_o[k]` is the XOR of the bits of `enc_data_i` selected by mask k. The masks, written {upper 32 bits, lower 32 bits} for k = 0..7, are: F00FE11E_C33C0FF7, 00FF00FF_00FFF0FF, 0F0F0F0F_0F0FFF00, 11113333_7777000F, 22224444_8888222F, 44448888_FFFF4441, 8888FFFF_11118882, FFFF1111_22221114. This output is combinational.
- R2: `syndrome_o` equals the R1 check bits of `dec_data_i` XOR `dec_check_i`.
- R3: A zero syndrome raises no error flag, and `dec_data_o` equals `dec_data_i`.
- R4: If the syndrome equals column b, `data_err_o` is 1 and `data_idx_o` is b. Bit k of column b is bit b of mask k. `dec_data_o` is `dec_data_i` with bit b inverted. If several columns match, the lowest b is used.
- R5: If the syndrome is nonzero, matches no column and has exactly one bit set, `check_err_o` is 1, `check_idx_o` is the position of that bit, and the data passes unchanged.
- R6: Any other nonzero syndrome sets `uncorr_o`, and the data passes unchanged.
- R7: At most one of the three flags is high. `data_idx_o` is 0 while `data_err_o` is low, and `check_idx_o` is 0 while `check_err_o` is low.
- R8: With `OUT_REG`=1 (the default), the decode outputs appear one clock after their inputs. While `rst_n` is low, all decode outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset |
| enc_data_i | input | 64 | Word to be protected |
| enc_check_o | output | 8 | Check bits for enc_data_i |
| dec_data_i | input | 64 | Word read back |
| dec_check_i | input | 8 | Check bits read back |
| dec_data_o | output | 64 | Corrected word |
| syndrome_o | output | 8 | Syndrome |
| data_err_o | output | 1 | Single data-bit error, also valid flag of data_idx_o |
| data_idx_o | output | 6 | Failing data bit |
| check_err_o | output | 1 | Single check-bit error, also valid flag of check_idx_o |
| check_idx_o | output | 3 | Failing check bit |
| uncorr_o | output | 1 | Uncorrectable error |

## Verification
The case hardest to reach is a multi-bit corruption whose syndrome aliases onto a data column or onto a single check bit. Random data alone almost never produces it. The stimulus therefore builds valid codewords and then flips two distinct random positions of the 72-bit codeword. It also drives fully random check bits, so that many syndromes are tried against the column table. Every one of the 72 single-position flips is applied directly as well.

// File: rtl/secded64_pkg.sv
package secded64_pkg;
   localparam int WORD_W = 64;
   localparam int PAR_W  = 8;

   // Selection mask of check bit k, {upper half, lower half}
   function automatic logic [WORD_W-1:0] sel_mask(input int k);
      case (k)
         0:       return {32'hF00FE11E, 32'hC33C0FF7};
         1:       return {32'h00FF00FF, 32'h00FFF0FF};
         2:       return {32'h0F0F0F0F, 32'h0F0FFF00};
         3:       return {32'h11113333, 32'h7777000F};
         4:       return {32'h22224444, 32'h8888222F};
         5:       return {32'h44448888, 32'hFFFF4441};
         6:       return {32'h8888FFFF, 32'h11118882};
         default: return {32'hFFFF1111, 32'h22221114};
      endcase
   endfunction

   // Syndrome produced by a flip of data bit b
   function automatic logic [PAR_W-1:0] bit_column(input int b);
      logic [PAR_W-1:0] c;
      for (int k = 0; k < PAR_W; k++) c[k] = sel_mask(k)[b];
      return c;
   endfunction

   typedef struct packed {
      logic [WORD_W-1:0]         data;
      logic [PAR_W-1:0]          syn;
      logic                      data_err;
      logic [$clog2(WORD_W)-1:0] didx;
      logic                      check_err;
      logic [$clog2(PAR_W)-1:0]  cidx;
      logic                      uncorr;
   } dec_res_t;
endpackage

// File: rtl/secded64_parity.sv
module secded64_parity
   import secded64_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CHK_W-1:0]  check_o
);
   for (genvar k = 0; k < CHK_W; k++) begin : g_tree
      assign check_o[k] = ^(data_i & sel_mask(k));
   end
endmodule

// File: rtl/secded64_locate.sv
module secded64_locate
   import secded64_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [CHK_W-1:0]  syn_i,
   output logic              hit_o,
   output logic [IDX_W-1:0]  idx_o
);
   logic [DATA_W-1:0] match;

   for (genvar b = 0; b < DATA_W; b++) begin : g_col
      assign match[b] = (syn_i == bit_column(b));
   end

   // lowest matching column wins
   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int b = DATA_W - 1; b >= 0; b--) begin
         if (match[b]) begin
            hit_o = 1'b1;
            idx_o = IDX_W'(b);
         end
      end
   end
endmodule

// File: rtl/secded64_classify.sv
module secded64_classify
   import secded64_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] data_i,
   input  logic [CHK_W-1:0]  check_i,
   output dec_res_t          res_o
);
   localparam int DIDX_W = $clog2(DATA_W);
   localparam int CIDX_W = $clog2(CHK_W);

   logic [CHK_W-1:0]  recomp;
   logic [CHK_W-1:0]  syn;
   logic              hit;
   logic [DIDX_W-1:0] hit_idx;
   logic              single;
   logic [CIDX_W-1:0] set_pos;

   secded64_parity #(.DATA_W(DATA_W), .CHK_W(CHK_W)) i_recomp (
      .data_i (data_i),
      .check_o(recomp)
   );

   assign syn = recomp ^ check_i;

   secded64_locate #(.DATA_W(DATA_W), .CHK_W(CHK_W)) i_locate (
      .syn_i(syn),
      .hit_o(hit),
      .idx_o(hit_idx)
   );

   assign single = $onehot(syn);

   always_comb begin
      set_pos = '0;
      for (int k = 0; k < CHK_W; k++) if (syn[k]) set_pos = CIDX_W'(k);
   end

   always_comb begin
      res_o.syn       = syn;
      res_o.data_err  = hit;
      res_o.didx      = hit ? hit_idx : '0;
      res_o.check_err = !hit && single;
      res_o.cidx      = (!hit && single) ? set_pos : '0;
      res_o.uncorr    = (syn != '0) && !hit && !single;
      res_o.data      = hit ? (data_i ^ (DATA_W'(1) << hit_idx)) : data_i;
   end

   p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({res_o.data_err, res_o.check_err, res_o.uncorr}));
   p_quiet_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (res_o.syn == '0) |-> (!res_o.data_err && !res_o.check_err && !res_o.uncorr
                             && res_o.data == data_i));
   p_one_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      res_o.data_err |-> ($countones(res_o.data ^ data_i) == 1));
   p_chk_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_o.check_err |-> (res_o.data == data_i && $countones(res_o.syn) == 1));
   p_unc_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_o.uncorr |-> (res_o.data == data_i && res_o.syn != '0));
endmodule

// File: rtl/secded64_codec.sv
module secded64_codec
   import secded64_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int CHK_W   = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int DIDX_W = $clog2(DATA_W),
   localparam int CIDX_W = $clog2(CHK_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] enc_data_i,
   output logic [CHK_W-1:0]  enc_check_o,
   input  logic [DATA_W-1:0] dec_data_i,
   input  logic [CHK_W-1:0]  dec_check_i,
   output logic [DATA_W-1:0] dec_data_o,
   output logic [CHK_W-1:0]  syndrome_o,
   output logic              data_err_o,
   output logic [DIDX_W-1:0] data_idx_o,
   output logic              check_err_o,
   output logic [CIDX_W-1:0] check_idx_o,
   output logic              uncorr_o
);
   if (DATA_W != WORD_W) begin : g_bad_data_w
      $error("secded64_codec: DATA_W must be 64");
   end
   if (CHK_W != PAR_W) begin : g_bad_chk_w
      $error("secded64_codec: CHK_W must be 8");
   end

   dec_res_t comb_res;
   dec_res_t out_res;

   secded64_parity #(.DATA_W(DATA_W), .CHK_W(CHK_W)) i_enc (
      .data_i (enc_data_i),
      .check_o(enc_check_o)
   );

   secded64_classify #(.DATA_W(DATA_W), .CHK_W(CHK_W)) i_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .data_i (dec_data_i),
      .check_i(dec_check_i),
      .res_o  (comb_res)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_res <= '0;
         else        out_res <= comb_res;
      end
   end else begin : g_flow
      assign out_res = comb_res;
   end

   assign dec_data_o  = out_res.data;
   assign syndrome_o  = out_res.syn;
   assign data_err_o  = out_res.data_err;
   assign data_idx_o  = out_res.didx;
   assign check_err_o = out_res.check_err;
   assign check_idx_o = out_res.cidx;
   assign uncorr_o    = out_res.uncorr;
endmodule

// File: tb/test_secded64_codec.sv
module test_secded64_codec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] enc_data_i = '0;
   logic [7:0]  enc_check_o;
   logic [63:0] dec_data_i = '0;
   logic [7:0]  dec_check_i = '0;
   logic [63:0] dec_data_o;
   logic [7:0]  syndrome_o;
   logic        data_err_o, check_err_o, uncorr_o;
   logic [5:0]  data_idx_o;
   logic [2:0]  check_idx_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   secded64_codec i_secded64_codec (
      .clk(clk), .rst_n(rst_n),
      .enc_data_i(enc_data_i), .enc_check_o(enc_check_o),
      .dec_data_i(dec_data_i), .dec_check_i(dec_check_i),
      .dec_data_o(dec_data_o), .syndrome_o(syndrome_o),
      .data_err_o(data_err_o), .data_idx_o(data_idx_o),
      .check_err_o(check_err_o), .check_idx_o(check_idx_o),
      .uncorr_o(uncorr_o)
   );

   function automatic logic [63:0] m_mask(int k);
      logic [31:0] hi [8] = '{32'hF00FE11E, 32'h00FF00FF, 32'h0F0F0F0F, 32'h11113333,
                              32'h22224444, 32'h44448888, 32'h8888FFFF, 32'hFFFF1111};
      logic [31:0] lo [8] = '{32'hC33C0FF7, 32'h00FFF0FF, 32'h0F0FFF00, 32'h7777000F,
                              32'h8888222F, 32'hFFFF4441, 32'h11118882, 32'h22221114};
      return {hi[k], lo[k]};
   endfunction

   function automatic logic [7:0] m_ecc(logic [63:0] d);
      logic [7:0] e = '0;
      for (int k = 0; k < 8; k++)
         for (int b = 0; b < 64; b++)
            if (m_mask(k)[b]) e[k] = e[k] ^ d[b];
      return e;
   endfunction

   function automatic logic [7:0] m_col(int b);
      logic [7:0] c;
      for (int k = 0; k < 8; k++) c[k] = m_mask(k)[b];
      return c;
   endfunction

   task automatic apply(input logic [63:0] d, input logic [7:0] c);
      logic [7:0]  syn;
      logic [63:0] x_data;
      logic        x_de, x_ce, x_un;
      logic [5:0]  x_di;
      logic [2:0]  x_ci;
      string       tag;
      syn = m_ecc(d) ^ c;                          // R2
      x_data = d; x_de = 0; x_ce = 0; x_un = 0; x_di = 0; x_ci = 0;
      tag = "R3";
      if (syn != 0) begin
         for (int b = 63; b >= 0; b--)
            if (m_col(b) == syn) begin x_de = 1; x_di = 6'(b); end
         if (x_de) begin
            x_data = d ^ (64'd1 << x_di); tag = "R4";
         end else if ($countones(syn) == 1) begin
            x_ce = 1; tag = "R5";
            for (int k = 0; k < 8; k++) if (syn[k]) x_ci = 3'(k);
         end else begin
            x_un = 1; tag = "R6";
         end
      end
      @(negedge clk);
      enc_data_i = d; dec_data_i = d; dec_check_i = c;
      #1;
      n_vec++;
      if (enc_check_o !== m_ecc(d)) begin
         n_bad++;
         $display("FAIL R1 enc_check got %h exp %h", enc_check_o, m_ecc(d));
      end
      @(negedge clk);   // registered decode (R8): one clock later
      n_vec++;
      if ({dec_data_o, syndrome_o, data_err_o, data_idx_o, check_err_o, check_idx_o, uncorr_o}
          !== {x_data, syn, x_de, x_di, x_ce, x_ci, x_un}) begin
         n_bad++;
         $display("FAIL %s/R2/R7 got d=%h s=%h de=%b di=%0d ce=%b ci=%0d u=%b exp d=%h s=%h de=%b di=%0d ce=%b ci=%0d u=%b",
                  tag, dec_data_o, syndrome_o, data_err_o, data_idx_o, check_err_o,
                  check_idx_o, uncorr_o, x_data, syn, x_de, x_di, x_ce, x_ci, x_un);
      end
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      logic [71:0] cw;
      int unused_seed;
      unused_seed = $urandom(32'h5EC0DED);
      dec_data_i = 64'hDEAD_BEEF_0123_4567; dec_check_i = 8'hA5;
      repeat (3) @(negedge clk);
      n_vec++;   // R8 reset state
      if ({dec_data_o, syndrome_o, data_err_o, data_idx_o, check_err_o, check_idx_o, uncorr_o} !== '0) begin
         n_bad++;
         $display("FAIL R8 reset outputs got d=%h s=%h exp 0", dec_data_o, syndrome_o);
      end
      rst_n = 1'b1;
      apply(64'h0, 8'h0);
      apply('1, m_ecc('1));
      apply(64'h0, 8'hFF);
      d = {$urandom, $urandom};
      for (int b = 0; b < 64; b++) apply(d ^ (64'd1 << b), m_ecc(d));   // R4 each column
      for (int k = 0; k < 8; k++) apply(d, m_ecc(d) ^ (8'd1 << k));     // R5 each check bit
      for (int i = 0; i < 1500; i++) begin
         int mode, p, q;
         d = {$urandom, $urandom};
         cw = {m_ecc(d), d};
         mode = $urandom_range(0, 4);
         p = $urandom_range(0, 71);
         q = (p + $urandom_range(1, 71)) % 72;
         case (mode)
            0: ;
            1: cw[p] = ~cw[p];
            2: begin cw[p] = ~cw[p]; cw[q] = ~cw[q]; end   // R6 / aliasing
            3: cw[71:64] = 8'($urandom);
            default: begin cw[p] = ~cw[p]; cw[q] = ~cw[q]; cw[(q + 1) % 72] = ~cw[(q + 1) % 72]; end
         endcase
         apply(cw[63:0], cw[71:64]);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule